// File: doc/BRIEF.md
# Microcontroller Special Register Access Unit

This unit carries out the move-to and move-from special register operations of a microcontroller-profile core. The core presents a 5-bit selector together with a read strobe, a write strobe and 32-bit write data. The unit holds the condition flags, the execution-state bits, the two stack pointers, the interrupt-disable and fault-disable bits, the base priority and a 2-bit control register. The exception number is owned by the exception logic and enters on its own input. The unit merges it into the combined status word.

A read returns the addressed register, combinationally and in the same cycle. A status view is returned through the mask for its selector. A write takes effect at the next clock edge. Every status view has its own write mask. The two stack pointers are banked: one copy is the live stack register and the other is the saved copy. Control bit 1 decides which pointer is live, and changing that bit exchanges the two copies. The raise-only base-priority selector changes the priority only in the direction of a stronger mask. The active stack select, both disable bits and the base priority are driven out to the rest of the core.

Top module: `sysreg_unit`

## Requirements
- R1: The combined status word holds stored bits 31:25 and 15:10 and the exception-number input in bits 8:0. Bit 24 and all other bits read 0. A read returns this word ANDed with the mask for its selector: sel 0 → F8000000, sel 1 → F80001FF, sel 2 → FF00FC00, sel 3 → FF00FDFF, sel 5 → 000001FF, sel 6 → 0700FC00, sel 7 → 0700EDFF (hex).
- R2: A write to a status view replaces only the stored bits under that view's write mask: sel 0 and 1 → F8000000, sel 2 and 3 → FE00FC00, sel 6 and 7 → 0600FC00. All other stored bits keep their value.
- R3: A write to sel 5 does not change any stored state.
- R4: Sel 8 reads and writes the main stack pointer and sel 9 the process stack pointer. Each one maps to the live copy (`sp_live_o`) when it is the active pointer, and to the saved copy otherwise.
- R5: Sel 16 and sel 17 read as 0 or 1, giving the interrupt-disable bit and the fault-disable bit. A write to either one loads that bit from data bit 0. The bits drive `irq_off_o` and `fault_off_o`.
- R6: A write to sel 18 loads data bits 7:0 into the base priority. Both sel 18 and sel 19 read the base priority, zero-extended.
- R7: A write to sel 19 loads data bits 7:0 into the base priority only when that value is nonzero and the current base priority is either zero or greater than the value. Otherwise the base priority is unchanged.
- R8: A write to sel 20 stores data bits 1:0 in control, and sel 20 reads them back. Control bit 1 set makes the process stack pointer active (`psp_sel_o`=1). When bit 1 changes, the live and saved copies are exchanged in the same edge.
- R9: A strobe on any selector other than 0–3, 5–9 or 16–20 raises `err_o` in that cycle, reads as 0 and changes no state.
- R10: After reset, all stored status bits, both stack pointers, both disable bits, the base priority and control are 0, and the main stack pointer is active.
- R11: While `rd_i` is low, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 5 | Special register selector |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| exc_num_i | input | 9 | Current exception number from exception logic |
| rdata_o | output | 32 | Read data, same cycle |
| err_o | output | 1 | Unknown selector strobed |
| psp_sel_o | output | 1 | Process stack pointer is active |
| irq_off_o | output | 1 | Interrupt-disable bit |
| fault_off_o | output | 1 | Fault-disable bit |
| basepri_o | output | 8 | Base priority |
| sp_live_o | output | 32 | Live stack register copy |

## Verification
A random mix of reads and writes covers every selector, including unknown ones. Write data and exception numbers are random. After each operation the bench compares the read data and the exported state with a reference model. Writes of all-ones and all-zeros through each status view, followed by a full read, show that each view's write mask is separate from its read mask, and that the read-only view is ignored. Raise-only writes of zero, of a larger value, of a smaller value and of an equal value separate the conditional update from a plain load. Toggling control bit 1 with different values in the two stack pointers separates a true exchange from a simple re-mapping.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DW     = 32;
  localparam int SEL_W  = 5;
  localparam int PRIO_W = 8;
  localparam int EXC_W  = 9;
  localparam int CTRL_W = 2;

  localparam logic [DW-1:0] STORE_MASK = 32'hFE00FC00;

  localparam logic [SEL_W-1:0] S_MAIN_SP  = 5'd8;
  localparam logic [SEL_W-1:0] S_PROC_SP  = 5'd9;
  localparam logic [SEL_W-1:0] S_IRQ_OFF  = 5'd16;
  localparam logic [SEL_W-1:0] S_FLT_OFF  = 5'd17;
  localparam logic [SEL_W-1:0] S_PRIO     = 5'd18;
  localparam logic [SEL_W-1:0] S_PRIO_UP  = 5'd19;
  localparam logic [SEL_W-1:0] S_CTRL     = 5'd20;
  localparam logic [SEL_W-1:0] S_EXC_VIEW = 5'd5;

  function automatic logic is_status(input logic [SEL_W-1:0] s);
    return (s <= 5'd7) && (s != 5'd4);
  endfunction

  function automatic logic sel_known(input logic [SEL_W-1:0] s);
    return is_status(s) || (s == S_MAIN_SP) || (s == S_PROC_SP) ||
           ((s >= S_IRQ_OFF) && (s <= S_CTRL));
  endfunction

  function automatic logic [DW-1:0] view_rmask(input logic [SEL_W-1:0] s);
    case (s)
      5'd0:    return 32'hF8000000;
      5'd1:    return 32'hF80001FF;
      5'd2:    return 32'hFF00FC00;
      5'd3:    return 32'hFF00FDFF;
      5'd5:    return 32'h000001FF;
      5'd6:    return 32'h0700FC00;
      5'd7:    return 32'h0700EDFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] view_wmask(input logic [SEL_W-1:0] s);
    case (s)
      5'd0, 5'd1: return 32'hF8000000;
      5'd2, 5'd3: return 32'hFE00FC00;
      5'd6, 5'd7: return 32'h0600FC00;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [PRIO_W-1:0] prio_raise(input logic [PRIO_W-1:0] cur,
                                                   input logic [PRIO_W-1:0] req);
    if ((req != '0) && ((cur == '0) || (req < cur))) return req;
    return cur;
  endfunction
endpackage

// File: rtl/sysreg_status.sv
module sysreg_status
  import sysreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [EXC_W-1:0] exc_num_i,
  output logic [DW-1:0]    view_o
);
  logic [DW-1:0] psr_q;
  logic [DW-1:0] wmask;
  logic          write_hit;
  logic [DW-1:0] status_word;

  assign wmask     = view_wmask(sel_i);
  assign write_hit = wr_en_i && is_status(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         psr_q <= '0;
    else if (write_hit) psr_q <= (psr_q & ~wmask) | (wdata_i & wmask);
  end

  assign status_word = (psr_q & STORE_MASK) | {{(DW-EXC_W){1'b0}}, exc_num_i};
  assign view_o      = status_word & view_rmask(sel_i);

  // R3: the exception view never alters stored bits
  assert_exc_view_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == S_EXC_VIEW) |=> (psr_q == $past(psr_q)));

  // R2: bits outside the write mask survive a status write
  assert_wmask_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_hit |=> (((psr_q ^ $past(psr_q)) & ~$past(wmask)) == '0));
endmodule

// File: rtl/sysreg_stack.sv
module sysreg_stack
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     main_sp_o,
  output logic [DW-1:0]     proc_sp_o,
  output logic [DW-1:0]     live_sp_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              psp_sel_o
);
  logic [DW-1:0]     live_q, saved_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              psp_act;
  logic              wr_main, wr_proc, wr_ctrl, swap;

  assign psp_act = ctrl_q[1];
  assign wr_main = wr_en_i && (sel_i == S_MAIN_SP);
  assign wr_proc = wr_en_i && (sel_i == S_PROC_SP);
  assign wr_ctrl = wr_en_i && (sel_i == S_CTRL);
  assign swap    = wr_ctrl && (wdata_i[1] != ctrl_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      saved_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (swap) begin
        live_q  <= saved_q;
        saved_q <= live_q;
      end else if (wr_main) begin
        if (psp_act) saved_q <= wdata_i;
        else         live_q  <= wdata_i;
      end else if (wr_proc) begin
        if (psp_act) live_q  <= wdata_i;
        else         saved_q <= wdata_i;
      end
    end
  end

  assign main_sp_o = psp_act ? saved_q : live_q;
  assign proc_sp_o = psp_act ? live_q  : saved_q;
  assign live_sp_o = live_q;
  assign ctrl_o    = ctrl_q;
  assign psp_sel_o = psp_act;

  // R8: a change of active pointer brings the saved copy live
  assert_swap_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psp_sel_o != $past(psp_sel_o)) |-> (live_q == $past(saved_q)));

  // R4: a main stack pointer write is visible through its alias
  assert_main_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main |=> (main_sp_o == $past(wdata_i)));
endmodule

// File: rtl/sysreg_prio.sv
module sysreg_prio
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_en_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic              irq_off_o,
  output logic              fault_off_o,
  output logic [PRIO_W-1:0] basepri_o
);
  logic              irq_q, flt_q;
  logic [PRIO_W-1:0] bp_q;
  logic              wr_irq, wr_flt, wr_bp, wr_bp_up;

  assign wr_irq   = wr_en_i && (sel_i == S_IRQ_OFF);
  assign wr_flt   = wr_en_i && (sel_i == S_FLT_OFF);
  assign wr_bp    = wr_en_i && (sel_i == S_PRIO);
  assign wr_bp_up = wr_en_i && (sel_i == S_PRIO_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      flt_q <= 1'b0;
      bp_q  <= '0;
    end else begin
      if (wr_irq)   irq_q <= wdata_i[0];
      if (wr_flt)   flt_q <= wdata_i[0];
      if (wr_bp)    bp_q  <= wdata_i;
      if (wr_bp_up) bp_q  <= prio_raise(bp_q, wdata_i);
    end
  end

  assign irq_off_o   = irq_q;
  assign fault_off_o = flt_q;
  assign basepri_o   = bp_q;

  // R7: the raise-only write keeps the value or moves to a stronger nonzero level
  assert_raise_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bp_up |=> ((bp_q == $past(bp_q)) ||
                  ((bp_q != '0) && (($past(bp_q) == '0) || (bp_q < $past(bp_q))))));

  // R5: interrupt-disable bit follows data bit 0
  assert_irq_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |=> (irq_off_o == $past(wdata_i[0])));
endmodule

// File: rtl/sysreg_unit.sv
module sysreg_unit
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              psp_sel_o,
  output logic              irq_off_o,
  output logic              fault_off_o,
  output logic [PRIO_W-1:0] basepri_o,
  output logic [DW-1:0]     sp_live_o
);
  logic              sel_ok, wr_ok;
  logic [DW-1:0]     status_view, main_sp, proc_sp, rd_view;
  logic [CTRL_W-1:0] ctrl;

  assign sel_ok = sel_known(sel_i);
  assign wr_ok  = wr_i && sel_ok;
  assign err_o  = (rd_i || wr_i) && !sel_ok;

  sysreg_status u_status (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_ok),
    .wdata_i(wdata_i), .exc_num_i(exc_num_i), .view_o(status_view)
  );

  sysreg_stack u_stack (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_ok),
    .wdata_i(wdata_i), .main_sp_o(main_sp), .proc_sp_o(proc_sp),
    .live_sp_o(sp_live_o), .ctrl_o(ctrl), .psp_sel_o(psp_sel_o)
  );

  sysreg_prio u_prio (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_ok),
    .wdata_i(wdata_i[PRIO_W-1:0]), .irq_off_o(irq_off_o),
    .fault_off_o(fault_off_o), .basepri_o(basepri_o)
  );

  always_comb begin
    rd_view = '0;
    if (is_status(sel_i)) rd_view = status_view;
    else begin
      case (sel_i)
        S_MAIN_SP:           rd_view = main_sp;
        S_PROC_SP:           rd_view = proc_sp;
        S_IRQ_OFF:           rd_view = {{(DW-1){1'b0}}, irq_off_o};
        S_FLT_OFF:           rd_view = {{(DW-1){1'b0}}, fault_off_o};
        S_PRIO, S_PRIO_UP:   rd_view = {{(DW-PRIO_W){1'b0}}, basepri_o};
        S_CTRL:              rd_view = {{(DW-CTRL_W){1'b0}}, ctrl};
        default:             rd_view = '0;
      endcase
    end
  end

  assign rdata_o = (rd_i && sel_ok) ? rd_view : '0;

  // R9: an unknown selector leaves every stored register untouched
  assert_err_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && wr_i) |=> ($stable(main_sp) && $stable(proc_sp) && $stable(ctrl) &&
                         $stable(basepri_o) && $stable(irq_off_o) && $stable(fault_off_o)));

  // R11: no read strobe, no read data
  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/sysreg_unit_bench.sv
module sysreg_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [8:0]  exc = '0;
  logic [31:0] rdata, sp_live;
  logic        err, psp_sel, irq_off, fault_off;
  logic [7:0]  basepri;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_psr = '0, m_live = '0, m_saved = '0;
  logic [1:0]  m_ctrl = '0;
  logic        m_irq = 1'b0, m_flt = 1'b0;
  logic [7:0]  m_bp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_unit u_sysreg_unit (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .exc_num_i(exc), .rdata_o(rdata), .err_o(err), .psp_sel_o(psp_sel),
    .irq_off_o(irq_off), .fault_off_o(fault_off), .basepri_o(basepri), .sp_live_o(sp_live)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] b_rmask(input int s);
    logic [31:0] flags = 32'hF8000000, exc_f = 32'h000001FF, st = 32'h0700FC00;
    case (s)
      0: return flags;
      1: return flags | exc_f;
      2: return flags | st;
      3: return flags | st | exc_f;
      5: return exc_f;
      6: return st;
      7: return (st | exc_f) & ~32'h00001000 & ~32'h00000200 | 32'h00000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] b_wmask(input int s);
    if (s == 0 || s == 1) return 32'hF8000000;
    if (s == 2 || s == 3) return 32'hFE00FC00;
    if (s == 6 || s == 7) return 32'h0600FC00;
    return 32'h0;
  endfunction

  function automatic bit b_valid(input int s);
    return (s >= 0 && s <= 9 && s != 4) || (s >= 16 && s <= 20);
  endfunction

  function automatic string b_req(input int s);
    if (!b_valid(s)) return "R9";
    if (s <= 7) return "R1";
    if (s <= 9) return "R4";
    if (s <= 17) return "R5";
    if (s <= 19) return "R6";
    return "R8";
  endfunction

  function automatic logic [31:0] b_read(input int s, input logic [8:0] e);
    logic [31:0] word = (m_psr & 32'hFE00FC00) | {23'b0, e};
    if (s <= 7) return word & b_rmask(s);
    case (s)
      8:  return m_ctrl[1] ? m_saved : m_live;
      9:  return m_ctrl[1] ? m_live : m_saved;
      16: return {31'b0, m_irq};
      17: return {31'b0, m_flt};
      18, 19: return {24'b0, m_bp};
      20: return {30'b0, m_ctrl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input int s, input logic [31:0] d);
    logic [31:0] t;
    if (!b_valid(s)) return;
    if (s <= 7) m_psr = (m_psr & ~b_wmask(s)) | (d & b_wmask(s));
    else if (s == 8) begin if (m_ctrl[1]) m_saved = d; else m_live = d; end
    else if (s == 9) begin if (m_ctrl[1]) m_live = d; else m_saved = d; end
    else if (s == 16) m_irq = d[0];
    else if (s == 17) m_flt = d[0];
    else if (s == 18) m_bp = d[7:0];
    else if (s == 19) begin
      if (d[7:0] != 0 && (m_bp == 0 || d[7:0] < m_bp)) m_bp = d[7:0];
    end else if (s == 20) begin
      if (d[1] != m_ctrl[1]) begin t = m_live; m_live = m_saved; m_saved = t; end
      m_ctrl = d[1:0];
    end
  endtask

  task automatic op(input int s, input logic [31:0] d, input bit r, input bit w,
                    input logic [8:0] e, input string tag);
    @(negedge clk);
    sel = s[4:0]; wdata = d; rd = r; wr = w; exc = e;
    #1;
    check("R9", "err", {31'b0, err}, {31'b0, (r || w) && !b_valid(s)});
    if (r) check(tag == "" ? b_req(s) : tag, $sformatf("rdata sel %0d", s), rdata,
                 b_valid(s) ? b_read(s, e) : 32'h0);
    else check("R11", "idle rdata", rdata, 32'h0);
    @(posedge clk);
    if (w) model_write(s, d);
    #1;
    rd = 1'b0; wr = 1'b0;
    check("R8", "psp_sel", {31'b0, psp_sel}, {31'b0, m_ctrl[1]});
    check("R4", "live sp", sp_live, m_live);
    check("R5", "masks", {30'b0, irq_off, fault_off}, {30'b0, m_irq, m_flt});
    check("R6", "basepri", {24'b0, basepri}, {24'b0, m_bp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", "basepri", {24'b0, basepri}, 32'h0);
    check("R10", "sp_live", sp_live, 32'h0);
    check("R10", "sel/masks", {29'b0, psp_sel, irq_off, fault_off}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    op(3, 0, 1, 0, 9'h1A5, "R10");
    op(20, 0, 1, 0, 0, "R10");

    // R2: all-ones through each view, read full word
    op(0, 32'hFFFFFFFF, 0, 1, 0, "R2");
    op(3, 0, 1, 0, 9'h0FF, "R2");
    op(6, 32'hFFFFFFFF, 0, 1, 0, "R2");
    op(3, 0, 1, 0, 9'h155, "R2");
    op(1, 32'h0, 0, 1, 0, "R2");
    op(3, 0, 1, 0, 9'h000, "R2");
    op(2, 32'hFFFFFFFF, 0, 1, 0, "R2");
    op(3, 0, 1, 0, 9'h1FF, "R2");
    // R3: write to exception view is dropped
    op(5, 32'h00000000, 0, 1, 0, "R3");
    op(3, 0, 1, 0, 9'h003, "R3");
    op(7, 32'h0, 0, 1, 0, "R2");
    op(3, 0, 1, 0, 9'h0A0, "R2");

    // R4/R8: bank swap with distinct pointer values
    op(8, 32'h2000_1000, 0, 1, 0, "R4");
    op(9, 32'h2000_2000, 0, 1, 0, "R4");
    op(20, 32'h2, 0, 1, 0, "R8");
    op(8, 0, 1, 0, 0, "R4");
    op(9, 0, 1, 0, 0, "R4");
    op(9, 32'h2000_3000, 0, 1, 0, "R4");
    op(20, 32'h3, 0, 1, 0, "R8");
    op(20, 32'h1, 0, 1, 0, "R8");
    op(8, 0, 1, 0, 0, "R4");
    op(9, 0, 1, 0, 0, "R4");

    // R7: raise-only priority updates
    op(18, 32'h0, 0, 1, 0, "R6");
    op(19, 32'h140, 0, 1, 0, "R7");
    op(19, 32'h80, 0, 1, 0, "R7");
    op(19, 32'h20, 0, 1, 0, "R7");
    op(19, 32'h100, 0, 1, 0, "R7");
    op(19, 32'h20, 0, 1, 0, "R7");
    op(19, 0, 1, 0, 0, "R7");
    op(18, 32'hA0, 0, 1, 0, "R6");
    op(18, 0, 1, 0, 0, "R6");

    // R5 directed
    op(16, 32'hFFFFFFFE, 0, 1, 0, "R5");
    op(16, 32'h1, 0, 1, 0, "R5");
    op(17, 32'h3, 0, 1, 0, "R5");
    op(17, 0, 1, 0, 0, "R5");

    // R9: unknown selectors
    op(4, 32'hFFFFFFFF, 1, 1, 0, "R9");
    op(21, 32'hFFFFFFFF, 1, 1, 0, "R9");
    op(31, 32'h12345678, 0, 1, 0, "R9");
    op(12, 0, 1, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int s;
      logic [31:0] d;
      bit r, w;
      s = int'($urandom_range(0, 23));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'hFF;
      r = ($urandom_range(0, 2) != 0);
      w = ($urandom_range(0, 1) != 0);
      op(s, d, r, w, 9'($urandom()), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule